// File: doc/BRIEF.md
# Strap-Latched Clock Configuration Selector

This block decides the operating configuration of a clock generator. It reads four kinds of configuration pins. The first is a 3-bit output-frequency code. The second is a reference-frequency flag. The third is a spread enable. The fourth is a spread-style input that chooses between down spread and center spread. The frequency code, the reference flag and the spread enable are captured once, on the first clock edge after reset is released. Their captured values are then held until the next reset. The spread-style pin is never captured. It is followed live.

A software-select bit in a control register chooses where the effective configuration comes from. When it is clear, the effective configuration comes from the captured pins, plus the live spread-style pin. When it is set, it comes from writable shadow copies in the control register. The effective configuration is decoded into a divider index and a nominal output frequency in kHz, and all outputs are registered. A second, read-only register always shows the captured pin values, whatever software has written. The analog loop and the dividers that use these outputs live elsewhere.

Top module: `clkcfg_strap_ctrl`

## Requirements
- R1: The frequency code, reference flag and spread enable are captured on the first rising clock edge after rst_n goes high. Later changes on those pins alter neither the outputs nor the status register (address 1) until the next reset.
- R2: The divider index output equals the 3-bit frequency code. The nominal frequency output in kHz is 100000, 125000, 133330, 166670, 200000, 266660, 333330 or 400000 for codes 0 to 7, whichever value the reference flag has.
- R3: ref_is_14m is 1 when the effective reference flag is 1 (14.31818 MHz reference) and 0 when it is 0 (25 MHz reference).
- R4: After capture, the control register (address 0) reads with these fields. Bit 7 holds the reference flag, bits 6:4 the frequency code and bit 3 the spread enable, all as captured. Bit 2 is the software-select bit and reads 0. Bit 1 reads 0. Bit 0 holds the spread-style pin value as it was at the capture edge.
- R5: While the software-select bit is 0, a write to address 0 leaves bits 7:3 and bit 0 of the control register unchanged. Only bit 2 is taken from the write data.
- R6: While the software-select bit is 1, a write to address 0 updates all shadow fields. The outputs then follow the shadow fields: bit 7 sets the reference, bits 6:4 the code, bit 3 the spread enable and bit 0 spread_center.
- R7: The status register (address 1) reads as follows. Bit 7 is the captured reference flag. Bits 6:4 are the captured frequency code. Bit 3 is the captured spread enable. Bits 2:1 read 0. Bit 0 is the live spread-style pin. This holds in either mode.
- R8: In hardware mode (software-select 0), spread_center equals the spread-style pin as it was one clock earlier (1 = center spread, 0 = down spread). In software mode the pin has no effect on spread_center.
- R9: A write that changes the software-select bit takes effect at its write edge. The outputs move to the other source on the next rising edge in a single step.
- R10: While rst_n is low, all outputs are 0. Reading an address other than 0 or 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; capture follows its release |
| pin_fsel | input | 3 | Frequency code pins |
| pin_ref_sel | input | 1 | Reference flag pin (1 = 14.31818 MHz, 0 = 25 MHz) |
| pin_spread_en | input | 1 | Spread enable pin, active high |
| pin_spread_center | input | 1 | Spread style pin, live (1 = center ±0.25%, 0 = down 0 to -0.5%) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| div_idx | output | 3 | Registered divider index |
| freq_khz | output | 19 | Registered nominal output frequency in kHz |
| spread_en | output | 1 | Registered spread enable |
| spread_center | output | 1 | Registered spread style |
| ref_is_14m | output | 1 | Registered reference flag |

## Verification
The assertions take for granted that reset is held low for at least one clock. They also assume the capture edge, the first edge after release, is never used for a register write, because the capture load has priority there. The bench releases reset and waits two full cycles before any write. It drives all pins and the write port only on falling edges. The check on the live spread-style pin assumes the pin is synchronous to clk, and the bench changes it only on falling edges.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int FS_W    = 3;
  localparam int REG_W   = 8;
  localparam int FREQ_W  = 19;
  localparam int N_CODES = 1 << FS_W;

  // field positions shared by the control and status registers
  localparam int BIT_REF = 7;
  localparam int BIT_FS  = 4;
  localparam int BIT_SEN = 3;
  localparam int BIT_SW  = 2;
  localparam int BIT_CTR = 0;

  typedef struct packed {
    logic            ref_sel;
    logic [FS_W-1:0] fs;
    logic            spread_en;
    logic            spread_center;
  } cfg_t;

  function automatic logic [FREQ_W-1:0] nominal_khz(input logic [FS_W-1:0] idx);
    logic [FREQ_W-1:0] f;
    case (idx)
      3'd0:    f = 19'd100000;
      3'd1:    f = 19'd125000;
      3'd2:    f = 19'd133330;
      3'd3:    f = 19'd166670;
      3'd4:    f = 19'd200000;
      3'd5:    f = 19'd266660;
      3'd6:    f = 19'd333330;
      default: f = 19'd400000;
    endcase
    return f;
  endfunction

  function automatic logic [REG_W-1:0] pack_word(input cfg_t c, input logic mid_bit);
    logic [REG_W-1:0] w;
    w = '0;
    w[BIT_REF]               = c.ref_sel;
    w[BIT_FS +: FS_W]        = c.fs;
    w[BIT_SEN]               = c.spread_en;
    w[BIT_SW]                = mid_bit;
    w[BIT_CTR]               = c.spread_center;
    return w;
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import clkcfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FS_W-1:0] pin_fsel,
  input  logic            pin_ref_sel,
  input  logic            pin_spread_en,
  output logic            captured,
  output logic            cap_pulse,
  output logic [FS_W-1:0] held_fs,
  output logic            held_ref,
  output logic            held_sen
);
  assign cap_pulse = ~captured;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured <= 1'b0;
      held_fs  <= '0;
      held_ref <= 1'b0;
      held_sen <= 1'b0;
    end else if (cap_pulse) begin
      captured <= 1'b1;
      held_fs  <= pin_fsel;
      held_ref <= pin_ref_sel;
      held_sen <= pin_spread_en;
    end
  end

  // once captured, the held values never move
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && $past(captured)) |-> $stable({held_ref, held_fs, held_sen}));
endmodule

// File: rtl/ctrl_shadow.sv
module ctrl_shadow
  import clkcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  cfg_t             load_val,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wr_data,
  output logic             sw_sel,
  output cfg_t             shadow,
  output logic [REG_W-1:0] ctrl_word
);
  logic unused_wr_bit;
  assign unused_wr_bit = wr_data[1];

  cfg_t wr_val;
  assign wr_val = '{ref_sel:       wr_data[BIT_REF],
                    fs:            wr_data[BIT_FS +: FS_W],
                    spread_en:     wr_data[BIT_SEN],
                    spread_center: wr_data[BIT_CTR]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_sel <= 1'b0;
      shadow <= '0;
    end else if (load) begin
      sw_sel <= 1'b0;
      shadow <= load_val;
    end else if (wr_hit) begin
      sw_sel <= wr_data[BIT_SW];
      if (sw_sel) shadow <= wr_val;
    end
  end

  assign ctrl_word = pack_word(shadow, sw_sel);

  // writes in hardware mode must not reach the shadow fields
  assert_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !sw_sel && !load) |=> $stable(shadow));
endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              update,
  input  cfg_t              eff,
  output logic [FS_W-1:0]   div_idx,
  output logic [FREQ_W-1:0] freq_khz,
  output logic              spread_en,
  output logic              spread_center,
  output logic              ref_is_14m
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_idx       <= '0;
      freq_khz      <= '0;
      spread_en     <= 1'b0;
      spread_center <= 1'b0;
      ref_is_14m    <= 1'b0;
    end else if (update) begin
      div_idx       <= eff.fs;
      freq_khz      <= nominal_khz(eff.fs);
      spread_en     <= eff.spread_en;
      spread_center <= eff.spread_center;
      ref_is_14m    <= eff.ref_sel;
    end
  end
endmodule

// File: rtl/clkcfg_strap_ctrl.sv
module clkcfg_strap_ctrl
  import clkcfg_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FS_W-1:0]     pin_fsel,
  input  logic                pin_ref_sel,
  input  logic                pin_spread_en,
  input  logic                pin_spread_center,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [REG_W-1:0]    rd_data,
  output logic [FS_W-1:0]     div_idx,
  output logic [FREQ_W-1:0]   freq_khz,
  output logic                spread_en,
  output logic                spread_center,
  output logic                ref_is_14m
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);

  logic            captured, cap_pulse, held_ref, held_sen, sw_sel, wr_hit;
  logic [FS_W-1:0] held_fs;
  cfg_t            hw_cfg, shadow, eff;
  logic [REG_W-1:0] ctrl_word, stat_word;
  logic            hw_mode_live;

  strap_capture u_cap (
    .clk(clk), .rst_n(rst_n), .pin_fsel(pin_fsel), .pin_ref_sel(pin_ref_sel),
    .pin_spread_en(pin_spread_en), .captured(captured), .cap_pulse(cap_pulse),
    .held_fs(held_fs), .held_ref(held_ref), .held_sen(held_sen)
  );

  // hardware view: held pins plus the live spread-style pin
  assign hw_cfg = '{ref_sel: held_ref, fs: held_fs, spread_en: held_sen,
                    spread_center: pin_spread_center};

  assign wr_hit = wr_en && (wr_addr == CTRL_ADDR);

  ctrl_shadow u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(cap_pulse),
    .load_val('{ref_sel: pin_ref_sel, fs: pin_fsel, spread_en: pin_spread_en,
                spread_center: pin_spread_center}),
    .wr_hit(wr_hit), .wr_data(wr_data), .sw_sel(sw_sel), .shadow(shadow),
    .ctrl_word(ctrl_word)
  );

  assign eff          = sw_sel ? shadow : hw_cfg;
  assign hw_mode_live = captured && !sw_sel;

  cfg_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .update(captured), .eff(eff),
    .div_idx(div_idx), .freq_khz(freq_khz), .spread_en(spread_en),
    .spread_center(spread_center), .ref_is_14m(ref_is_14m)
  );

  assign stat_word = pack_word(hw_cfg, 1'b0);

  always_comb begin
    if (rd_addr == CTRL_ADDR)      rd_data = ctrl_word;
    else if (rd_addr == STAT_ADDR) rd_data = stat_word;
    else                           rd_data = '0;
  end

  // hardware mode: spread_center tracks the pin with one register of delay
  assert_live_ctr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hw_mode_live) |-> (spread_center == $past(pin_spread_center)));

  // software mode: outputs follow the shadow fields
  assert_sw_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_sel && captured) |-> (div_idx == $past(shadow.fs) &&
                                   ref_is_14m == $past(shadow.ref_sel)));
endmodule

// File: tb/clkcfg_strap_ctrl_test.sv
`timescale 1ns/1ps
module clkcfg_strap_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] pin_fsel = '0;
  logic pin_ref_sel = 1'b0, pin_spread_en = 1'b0, pin_spread_center = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [2:0] div_idx;
  logic [18:0] freq_khz;
  logic spread_en, spread_center, ref_is_14m;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  clkcfg_strap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_fsel(pin_fsel), .pin_ref_sel(pin_ref_sel),
    .pin_spread_en(pin_spread_en), .pin_spread_center(pin_spread_center),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .div_idx(div_idx), .freq_khz(freq_khz),
    .spread_en(spread_en), .spread_center(spread_center), .ref_is_14m(ref_is_14m)
  );

  function automatic int exp_khz(input int code);
    int t[8] = '{100000, 125000, 133330, 166670, 200000, 266660, 333330, 400000};
    return t[code % 8];
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a; #0.1; v = rd_data;
  endtask

  task automatic do_reset(input logic [2:0] fs, input logic rf, input logic se, input logic ct);
    @(negedge clk); rst_n = 1'b0;
    pin_fsel = fs; pin_ref_sel = rf; pin_spread_en = se; pin_spread_center = ct;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd0; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset_state;
    logic [7:0] v;
    @(negedge clk); rst_n = 1'b0; pin_fsel = 3'd7; pin_ref_sel = 1'b1;
    pin_spread_en = 1'b1; pin_spread_center = 1'b1;
    @(negedge clk);
    check("R10 div_idx in reset", div_idx, 0);
    check("R10 freq in reset", freq_khz, 0);
    check("R10 flags in reset", {spread_en, spread_center, ref_is_14m}, 0);
    read_reg(2'd2, v); check("R10 unmapped read", v, 0);
  endtask

  task automatic t_capture_hold;
    logic [7:0] v;
    do_reset(3'd6, 1'b1, 1'b1, 1'b0);
    read_reg(2'd0, v); check("R4 ctrl after capture", v, 8'b1110_1000);
    pin_fsel = 3'd1; pin_ref_sel = 1'b0; pin_spread_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 div_idx held", div_idx, 6);
    check("R1 ref held", ref_is_14m, 1);
    check("R1 spread_en held", spread_en, 1);
    read_reg(2'd1, v); check("R1 status held", v, 8'b1110_1000);
  endtask

  task automatic t_decode_sweep;
    for (int c = 0; c < 16; c++) begin
      do_reset(3'(c), c[3], c[0], 1'b0);
      check($sformatf("R2 idx code %0d", c), div_idx, c % 8);
      check($sformatf("R2 freq code %0d", c), freq_khz, exp_khz(c));
      check($sformatf("R3 ref code %0d", c), ref_is_14m, c / 8);
    end
  endtask

  task automatic t_locked_write;
    logic [7:0] v;
    do_reset(3'd2, 1'b0, 1'b0, 1'b1);
    write_ctrl(8'b1111_1001);
    @(negedge clk);
    read_reg(2'd0, v); check("R5 ctrl unchanged", v, 8'b0010_0001);
    check("R5 div_idx unchanged", div_idx, 2);
    check("R5 ref unchanged", ref_is_14m, 0);
  endtask

  task automatic t_sw_mode;
    logic [7:0] v;
    do_reset(3'd1, 1'b0, 1'b0, 1'b0);
    write_ctrl(8'h04);
    @(negedge clk);
    check("R6 sw on, shadow from straps", div_idx, 1);
    write_ctrl(8'b1101_1101);
    check("R9 one edge after write still old", div_idx, 1);
    @(negedge clk);
    check("R6 idx from shadow", div_idx, 5);
    check("R6 freq from shadow", freq_khz, 266660);
    check("R3 ref from shadow", ref_is_14m, 1);
    check("R6 spread_en from shadow", spread_en, 1);
    check("R6 center from shadow", spread_center, 1);
    pin_spread_center = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 pin ignored in sw mode", spread_center, 1);
    read_reg(2'd1, v); check("R7 status keeps straps", v, 8'b0001_0000);
    write_ctrl(8'h00);
    check("R9 sw still in effect", div_idx, 5);
    @(negedge clk);
    check("R9 back to hw idx", div_idx, 1);
    check("R9 back to hw ref", ref_is_14m, 0);
    check("R9 back to hw center", spread_center, 0);
  endtask

  task automatic t_live_spread;
    logic [7:0] v;
    do_reset(3'd4, 1'b1, 1'b0, 1'b0);
    pin_spread_center = 1'b1;
    read_reg(2'd1, v); check("R7 status live bit0", v, 8'b1100_0001);
    @(negedge clk);
    check("R8 center follows pin", spread_center, 1);
    pin_spread_center = 1'b0;
    @(negedge clk);
    check("R8 center follows pin low", spread_center, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset_state();
    t_capture_hold();
    t_decode_sweep();
    t_locked_write();
    t_sw_mode();
    t_live_spread();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule